// File: doc/BRIEF.md
# Multi-Port Cell Transmit Master

This block is the cell-source end of a byte-wide transmit interface that feeds up to four physical-layer ports. Each port has its own ready line, which it raises when it can take one more complete cell. The master watches every ready line at once. It holds a byte queue for each port, and an upstream source writes cells into these queues with valid, byte and last-byte strobes. When a port has a whole cell queued and its ready line is high, the master selects that port. It then sends the cell as 53 consecutive bytes on the data bus.

A cell always takes two phases. In the selection clock, the target port's number is driven on the address bus while the enable stays low. In the next clock, the enable rises, the start-of-cell flag marks the first byte, and the remaining bytes follow with no gaps. If the target port has dropped its ready line by the selection clock, the cell is not started and arbitration runs again. Ports with pending cells are served in round-robin order, starting after the port served most recently.

Top module: `mphy_cell_sender`

## Requirements
- R1: After reset, `tx_en` and `tx_soc` are 0, `tx_addr` is 0, and every `wr_room` bit is 1.
- R2: The address driven for port p (numbered 0 to NPORT-1) is the value p, so port 0 uses address 0 and port 1 uses address 1.
- R3: Every cell is preceded by exactly one clock in which `tx_en` is 0 and `tx_addr` already holds the target port's address.
- R4: In the clock after selection, `tx_en` is 1, `tx_soc` is 1, and `tx_data` carries the oldest byte queued for that port.
- R5: A started cell runs for exactly CELL_BYTES (53) consecutive clocks with `tx_en` at 1. `tx_soc` is 1 only in the first of those clocks, and the bytes leave in the order they were written.
- R6: A cell starts only if the target port's `phy_rdy` bit is 1 in the selection clock. Otherwise `tx_en` stays 0 and the master goes back to arbitration.
- R7: A port whose `phy_rdy` is 0 is never selected. If `phy_rdy` drops during a cell, that cell still finishes, and no further cell goes to that port while `phy_rdy` stays 0.
- R8: When several ready ports have whole cells queued, they are served in round-robin order, starting from the port after the one served last. After reset, the search starts at port 0.
- R9: A cell becomes eligible only once its byte marked by `wr_last` has been written. A partly written cell is never sent.
- R10: `wr_room[p]` is 0 when port p's queue holds QUEUE_CELLS*CELL_BYTES bytes. A write to a full queue is dropped and does not change the queued data.
- R11: Whenever `tx_en` is 0, `tx_soc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_rdy | input | NPORT | Per-port ready for one full cell |
| wr_valid | input | NPORT | Per-port byte write strobe |
| wr_data | input | NPORT*DATA_W | Per-port write byte, port p at bits p*DATA_W upward |
| wr_last | input | NPORT | Marks the final byte of a cell being written |
| wr_room | output | NPORT | Per-port queue can accept a byte |
| tx_addr | output | ADDR_W | Address of the selected port |
| tx_en | output | 1 | Transfer enable, active high |
| tx_soc | output | 1 | Start-of-cell flag on the first byte |
| tx_data | output | DATA_W | Cell byte stream |

## Verification
An error in the byte index or the state register shows up as a cell of the wrong length. It is visible at the next enable edge, which is at most 53 clocks later. A wrong queue pointer or cell count becomes a byte mismatch on the very next data byte, or causes a cell to be sent when no complete cell was written. A fault in the arbiter or the ready sampling changes the order in which port addresses appear, or starts a cell whose ready line was low one clock earlier. Both are detectable at the start-of-cell clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   typedef enum logic [1:0] {
      MCS_ARB  = 2'd0,
      MCS_SEL  = 2'd1,
      MCS_XFER = 2'd2
   } mcs_state_e;

endpackage

// File: rtl/mcs_cell_queue.sv
module mcs_cell_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 106,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              wr_room,
   input  logic              rd_pop,
   input  logic              rd_cell_done,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cell_cnt
);

   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_bad_depth
      $error("mcs_cell_queue: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  used, cells;
   logic              wr_fire;

   assign wr_room  = (used < CNT_W'(DEPTH));
   assign wr_fire  = wr_en && wr_room;
   assign rd_data  = mem[rd_ptr];
   assign cell_cnt = cells;

   // pointer wrap: free-running when depth is a power of two
   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         used   <= '0;
         cells  <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_nxt;
         if (rd_pop)  rd_ptr <= rd_nxt;
         used  <= used + CNT_W'(wr_fire) - CNT_W'(rd_pop);
         cells <= cells + CNT_W'(wr_fire && wr_last) - CNT_W'(rd_cell_done);
      end
   end

   p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> (used != '0));

   p_cell_before_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop |-> (cells != '0));

   p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_room) |=> (used == $past(used) - CNT_W'($past(rd_pop))));

endmodule

// File: rtl/mcs_rr_pick.sv
module mcs_rr_pick #(
   parameter int NPORT = 4,
   localparam int PORT_W = $clog2(NPORT)
) (
   input  logic [NPORT-1:0]  req,
   input  logic [PORT_W-1:0] last,
   output logic              any,
   output logic [PORT_W-1:0] grant
);

   always_comb begin
      any   = 1'b0;
      grant = '0;
      for (int k = 1; k <= NPORT; k++) begin
         int j;
         j = (int'(last) + k) % NPORT;
         if (!any && req[j]) begin
            any   = 1'b1;
            grant = PORT_W'(j);
         end
      end
   end

endmodule

// File: rtl/mcs_tx_seq.sv
module mcs_tx_seq
   import mcs_pkg::*;
#(
   parameter int NPORT      = 4,
   parameter int CELL_BYTES = 53,
   localparam int PORT_W = $clog2(NPORT),
   localparam int IDX_W  = $clog2(CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORT-1:0]  phy_rdy,
   input  logic              arb_any,
   input  logic [PORT_W-1:0] arb_grant,
   output logic [PORT_W-1:0] cur,
   output logic [PORT_W-1:0] last_srv,
   output logic              xfer_en,
   output logic              xfer_soc,
   output logic              xfer_end
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   mcs_state_e       st;
   logic [IDX_W-1:0] idx;
   logic             rdy_cur;

   assign rdy_cur  = phy_rdy[cur];
   assign xfer_en  = (st == MCS_XFER);
   assign xfer_soc = xfer_en && (idx == '0);
   assign xfer_end = xfer_en && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= MCS_ARB;
         cur      <= '0;
         idx      <= '0;
         last_srv <= PORT_W'(NPORT - 1);
      end else begin
         case (st)
            MCS_ARB: begin
               if (arb_any) begin
                  cur <= arb_grant;
                  st  <= MCS_SEL;
               end
            end
            MCS_SEL: begin
               if (rdy_cur) begin
                  st       <= MCS_XFER;
                  idx      <= '0;
                  last_srv <= cur;
               end else begin
                  st <= MCS_ARB;
               end
            end
            MCS_XFER: begin
               if (idx == LAST_IDX) begin
                  idx <= '0;
                  if (arb_any) begin
                     cur <= arb_grant;
                     st  <= MCS_SEL;
                  end else begin
                     st <= MCS_ARB;
                  end
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: st <= MCS_ARB;
         endcase
      end
   end

   p_sel_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_soc |-> (!$past(xfer_en) && $stable(cur)));

   p_rdy_at_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_soc |-> $past(rdy_cur));

   p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && !xfer_soc) |-> $past(xfer_en));

   p_cell_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |=> !xfer_en);

   p_idle_soc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_en |-> !xfer_soc);

endmodule

// File: rtl/mphy_cell_sender.sv
module mphy_cell_sender #(
   parameter int NPORT       = 4,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int CELL_BYTES  = 53,
   parameter int QUEUE_CELLS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORT-1:0]        phy_rdy,
   input  logic [NPORT-1:0]        wr_valid,
   input  logic [NPORT*DATA_W-1:0] wr_data,
   input  logic [NPORT-1:0]        wr_last,
   output logic [NPORT-1:0]        wr_room,
   output logic [ADDR_W-1:0]       tx_addr,
   output logic                    tx_en,
   output logic                    tx_soc,
   output logic [DATA_W-1:0]       tx_data
);

   localparam int PORT_W = $clog2(NPORT);
   localparam int DEPTH  = QUEUE_CELLS * CELL_BYTES;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   if (NPORT < 2 || NPORT > (1 << ADDR_W)) begin : g_bad_nport
      $error("mphy_cell_sender: NPORT must be 2..2**ADDR_W");
   end
   if (CELL_BYTES < 2) begin : g_bad_cell
      $error("mphy_cell_sender: CELL_BYTES must be at least 2");
   end
   if (QUEUE_CELLS < 1) begin : g_bad_queue
      $error("mphy_cell_sender: QUEUE_CELLS must be at least 1");
   end

   logic [DATA_W-1:0] q_data  [NPORT];
   logic [CNT_W-1:0]  q_cells [NPORT];
   logic [NPORT-1:0]  q_pop, q_done, pending, arb_req;
   logic [PORT_W-1:0] cur, last_srv, arb_grant;
   logic              arb_any, xfer_en, xfer_soc, xfer_end;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign q_pop[p]  = xfer_en  && (cur == PORT_W'(p));
      assign q_done[p] = xfer_end && (cur == PORT_W'(p));
      // the cell now leaving does not count toward the next pick
      assign pending[p] = (q_cells[p] > CNT_W'(q_pop[p]));

      mcs_cell_queue #(
         .DATA_W (DATA_W),
         .DEPTH  (DEPTH)
      ) u_queue (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_en        (wr_valid[p]),
         .wr_data      (wr_data[p*DATA_W +: DATA_W]),
         .wr_last      (wr_last[p]),
         .wr_room      (wr_room[p]),
         .rd_pop       (q_pop[p]),
         .rd_cell_done (q_done[p]),
         .rd_data      (q_data[p]),
         .cell_cnt     (q_cells[p])
      );
   end

   assign arb_req = phy_rdy & pending;

   mcs_rr_pick #(
      .NPORT (NPORT)
   ) u_pick (
      .req   (arb_req),
      .last  (last_srv),
      .any   (arb_any),
      .grant (arb_grant)
   );

   mcs_tx_seq #(
      .NPORT      (NPORT),
      .CELL_BYTES (CELL_BYTES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .phy_rdy   (phy_rdy),
      .arb_any   (arb_any),
      .arb_grant (arb_grant),
      .cur       (cur),
      .last_srv  (last_srv),
      .xfer_en   (xfer_en),
      .xfer_soc  (xfer_soc),
      .xfer_end  (xfer_end)
   );

   assign tx_addr = ADDR_W'(cur);
   assign tx_en   = xfer_en;
   assign tx_soc  = xfer_soc;
   assign tx_data = q_data[cur];

   p_grant_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      arb_any |-> (phy_rdy[arb_grant] && pending[arb_grant]));

   p_one_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_pop));

endmodule

// File: tb/mphy_cell_sender_tb.sv
module mphy_cell_sender_tb;

   localparam int NP = 4;
   localparam int CB = 53;
   localparam int QC = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   phy_rdy = '0;
   logic [NP-1:0]   wr_valid = '0;
   logic [NP*8-1:0] wr_data = '0;
   logic [NP-1:0]   wr_last = '0;
   logic [NP-1:0]   wr_room;
   logic [4:0]      tx_addr;
   logic            tx_en, tx_soc;
   logic [7:0]      tx_data;

   always #2 clk = ~clk;

   mphy_cell_sender u_dut (
      .clk(clk), .rst_n(rst_n), .phy_rdy(phy_rdy), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_last(wr_last), .wr_room(wr_room),
      .tx_addr(tx_addr), .tx_en(tx_en), .tx_soc(tx_soc), .tx_data(tx_data)
   );

   int  nchk = 0, nfail = 0, cyc = 0;
   bit  done = 0;
   byte unsigned exp_q[NP][$];
   int  served[$];

   task automatic check(bit ok, string tag, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rr_next(int last, bit [NP-1:0] mask);
      for (int k = 1; k <= NP; k++) begin
         int j;
         j = (last + k) % NP;
         if (mask[j]) return j;
      end
      return -1;
   endfunction

   // ---------------- monitor ----------------
   bit m_act = 0;
   int m_idx = 0, m_port = 0;
   bit p_en = 0, p_rdy = 0;
   int p_addr = 0;

   task automatic cmp_byte(string tag);
      if (m_port < NP && exp_q[m_port].size() > 0) begin
         byte unsigned e;
         e = exp_q[m_port].pop_front();
         check(tx_data == e, tag, tx_data, e);
      end else begin
         check(0, "R9 byte sent with nothing queued", tx_data, -1);
      end
      m_idx++;
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!tx_en) begin
            check(tx_soc == 1'b0, "R11 soc while idle", tx_soc, 0);
            if (m_act) begin
               check(m_idx == CB, "R5 cell length", m_idx, CB);
               m_act = 0;
            end
         end else if (tx_soc) begin
            if (m_act) check(0, "R5 cell cut short", m_idx, CB);
            check(!p_en && p_addr == int'(tx_addr), "R3 select clock", p_addr, tx_addr);
            check(p_rdy, "R6 ready on select clock", p_rdy, 1);
            check(tx_addr < NP && exp_q[tx_addr].size() >= CB,
                  "R2 address maps to loaded port", tx_addr, 0);
            m_act = 1; m_idx = 0; m_port = tx_addr;
            served.push_back(int'(tx_addr));
            cmp_byte("R4 first byte");
         end else begin
            if (!m_act || m_idx >= CB) check(0, "R5 byte outside cell", m_idx, CB - 1);
            cmp_byte("R5 cell byte");
         end
         p_en   = tx_en;
         p_addr = tx_addr;
         p_rdy  = (tx_addr < NP) ? phy_rdy[tx_addr] : 1'b0;
      end
   end

   // ---------------- drivers ----------------
   task automatic put_byte(int p, byte unsigned b, bit l);
      while (!wr_room[p]) begin @(posedge clk); #1; end
      wr_valid[p] = 1'b1;
      wr_data[p*8 +: 8] = b;
      wr_last[p] = l;
      @(posedge clk); #1;
      wr_valid[p] = 1'b0;
      wr_last[p]  = 1'b0;
      exp_q[p].push_back(b);
   endtask

   task automatic push_cell(int p);
      for (int i = 0; i < CB; i++) put_byte(p, 8'($urandom), i == CB - 1);
   endtask

   function automatic bit busy();
      for (int p = 0; p < NP; p++) if (exp_q[p].size() != 0) return 1;
      return tx_en;
   endfunction

   task automatic wait_idle(string tag);
      int n;
      n = 0;
      while (n < 3000 && busy()) begin @(posedge clk); #1; n++; end
      check(n < 3000, tag, n, 3000);
      @(posedge clk); #1;
   endtask

   task automatic check_order(int last0, bit [NP-1:0] mask, string tag);
      int l;
      l = last0;
      check(served.size() == $countones(mask), tag, served.size(), $countones(mask));
      for (int i = 0; i < served.size(); i++) begin
         int e;
         e = rr_next(l, mask);
         check(served[i] == e, tag, served[i], e);
         if (e >= 0) mask[e] = 1'b0;
         l = e;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         done = 1;
         nfail++;
         $display("FAIL watchdog (all requirements) actual=%0d expected=<%0d", cyc, 150000);
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      bit seen;
      bit wdone;
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(tx_en == 0 && tx_soc == 0, "R1 reset enable/soc", {tx_en, tx_soc}, 0);
      check(tx_addr == 0, "R1 reset address", tx_addr, 0);
      check(wr_room == '1, "R1 reset room", wr_room, 4'hF);
      @(posedge clk); #1;

      // R8 round robin from reset, R2 addresses
      for (int p = 0; p < NP; p++) push_cell(p);
      served.delete();
      phy_rdy = '1;
      wait_idle("R8 drain all ports");
      check_order(NP - 1, 4'hF, "R8 order after reset");
      phy_rdy = '0;
      for (int p = NP - 1; p >= 1; p -= 2) push_cell(p);
      served.delete();
      phy_rdy = '1;
      wait_idle("R8 drain ports 1 and 3");
      check_order(NP - 1, 4'b1010, "R8 order resumes after last served");

      // R9 partial cell held
      phy_rdy = 4'b0001;
      for (int i = 0; i < CB - 1; i++) put_byte(0, 8'($urandom), 1'b0);
      seen = 0;
      repeat (60) begin @(posedge clk); #1; if (tx_en) seen = 1; end
      check(!seen, "R9 partial cell not sent", seen, 0);
      put_byte(0, 8'hC3, 1'b1);
      wait_idle("R9 completed cell drains");

      // R6 ready falls in the selection clock
      phy_rdy = '0;
      push_cell(1);
      phy_rdy[1] = 1'b1;
      @(posedge clk); #1;
      phy_rdy[1] = 1'b0;
      seen = 0;
      repeat (30) begin @(posedge clk); #1; if (tx_en) seen = 1; end
      check(!seen, "R6 no cell when ready lost at selection", seen, 0);
      phy_rdy[1] = 1'b1;
      wait_idle("R6 cell sent after ready returns");

      // R7 ready drops mid-cell
      phy_rdy = '0;
      push_cell(2);
      push_cell(2);
      served.delete();
      phy_rdy[2] = 1'b1;
      while (!tx_en) begin @(posedge clk); #1; end
      phy_rdy[2] = 1'b0;
      repeat (80) begin @(posedge clk); #1; end
      check(served.size() == 1, "R7 one cell only while not ready", served.size(), 1);
      check(exp_q[2].size() == CB, "R7 cell finished, next held", exp_q[2].size(), CB);
      phy_rdy[2] = 1'b1;
      wait_idle("R7 drain");

      // R10 full queue
      phy_rdy = '0;
      for (int c = 0; c < QC; c++) push_cell(3);
      check(wr_room[3] == 1'b0, "R10 room low when full", wr_room[3], 0);
      wr_valid[3] = 1'b1; wr_data[24 +: 8] = 8'hAA; wr_last[3] = 1'b1;
      @(posedge clk); #1;
      wr_valid[3] = 1'b0; wr_last[3] = 1'b0;
      check(wr_room[3] == 1'b0, "R10 room stays low", wr_room[3], 0);
      served.delete();
      phy_rdy[3] = 1'b1;
      wait_idle("R10 drain full queue");
      check(served.size() == QC, "R10 dropped write made no cell", served.size(), QC);
      push_cell(3);
      wait_idle("R10 queue intact after drop");

      // random mix
      wdone = 0;
      served.delete();
      phy_rdy = 4'($urandom);
      fork
         begin
            repeat (40) push_cell($urandom_range(0, NP - 1));
            wdone = 1;
         end
         begin
            while (!wdone) begin
               @(posedge clk); #1;
               if ($urandom_range(0, 7) == 0) phy_rdy[$urandom_range(0, NP - 1)] ^= 1'b1;
            end
         end
      join
      phy_rdy = '1;
      wait_idle("R5 random traffic drains");
      check(served.size() == 40, "R5 random cells delivered", served.size(), 40);

      repeat (4) @(posedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule